// File: doc/BRIEF.md
# Host Remote DMA Buffer Port

This block gives a local processor byte- or word-wide access to a packet buffer through a small register window of 32 offsets. The host programs a start address and a byte count into page-0 registers, then writes a command byte that starts a transfer in one of two directions. In the buffer-to-host direction, the engine fetches the first word as soon as the command is taken. Each read of the data port then returns fresh data at once. In the host-to-buffer direction, each data-port write is stored directly. Every data-port access advances the address and reduces the remaining count by the access width. When the count runs out, a completion flag is set in a write-one-to-clear status register and the engine goes idle. An abort bit stops a transfer immediately.

Two address maps are available. In compatibility mode (the reset default), every buffer address is folded into the second quarter of the buffer. In extension mode, the whole buffer is reachable and addresses wrap at the top. The buffer is modelled as a synchronous two-lane byte array sized by `BUF_AW`, the byte-address width. With `BUF_AW = 16`, the compatibility window is 4000h to 7FFFh.

Host accesses use a valid/ready request channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` drops for exactly one cycle while a prefetch is in flight, so the host must hold its request until it is taken. Every taken read produces `rsp_valid` for one cycle, on the cycle after it is taken, together with `rsp_data`. The response path has no back-pressure. The receive-done and transmit-done event inputs are plain one-cycle pulses.

Top module: `rdma_host_port`

## Requirements
- R1: After reset, the following hold: the engine is idle; `req_ready` is 1; `rsp_valid` is 0; page 0 is selected; compatibility mode is active; the address, count and status registers all read 0.
- R2: Page-0 offsets hold the 16-bit start address and the 16-bit count, each as two 8-bit registers: 02h address low, 03h address high, 04h count low, 05h count high. Reads return the current value. Writes to these registers are ignored while a transfer is active.
- R3: Writing the command register (offset 00h) with bits [4:3] = 01 starts a buffer-to-host transfer and fetches the first word. `req_ready` is 0 in the cycle after the command is taken. The first read of the data port (offset 10h) then returns the byte at the start address.
- R4: Writing bits [4:3] = 10 starts a host-to-buffer transfer, in which each data-port write stores data at the current address. While a transfer is active, the command register reads back this field as 01 (read) or 10 (write). It reads back 00 when the engine is idle.
- R5: A byte access (`req_word` = 0) moves one byte on lane [7:0], advances the address by 1 and lowers the count by 1. An odd address selects the high byte of the stored word.
- R6: A word access moves the even byte on the low lane and the odd byte on the high lane. It advances the address by 2 and lowers the count by 2; a count of 1 drops to 0.
- R7: A command or data-port access that leaves the count at 0 has three effects: status bit 6 is set, the engine returns to idle, and later data-port reads return 0 and data-port writes are ignored. A start command issued with a count of 0 completes at once.
- R8: Command bit 5 aborts at once. The engine goes idle and address and count keep their values. No completion is flagged.
- R9: A command write with bit 5 = 0 and bits [4:3] = 11 is ignored entirely: the page, the state and all registers are unchanged.
- R10: In compatibility mode, the effective byte address has its top two bits forced to 01, so transfers wrap inside the second quarter of the buffer.
- R11: In extension mode (page-1 offset 01h, bit 0 = 1), the whole buffer is reachable, and the address wraps from the top to 0.
- R12: Command bits [7:6] select the page. Page-0 registers read 0 and ignore writes in page 1. The command register at 00h and the data port at 10h are present in every page.
- R13: Status register (page 0, offset 07h) has three bits. Bit 0 is set by `rx_done`, bit 1 by `tx_done` and bit 6 by completion. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R14: A taken read yields `rsp_valid` = 1 on the next cycle only; no response appears otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit data-port access, 0 = byte |
| req_offset | input | 5 | Register offset in the 32-entry window |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 16 | Read response data |
| rx_done | input | 1 | Pulse: packet received intact |
| tx_done | input | 1 | Pulse: packet sent intact |

## Verification
The bench builds the block with `BUF_AW = 6`: a 64-byte buffer of 32 words with a 16-byte compatibility window. A single transfer can therefore sweep every byte location, and in both maps the address can run past the end and wrap. This makes it possible to sweep every byte and word of the buffer against an arithmetic pattern, and to check the fold of junk high address bits. Word transfers are driven across the window edge, and odd counts, aborts mid-transfer, illegal commands and page hiding are each checked at the register ports.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RDY   = 2'd2,
    ST_WR    = 2'd3
  } rdma_state_t;

  localparam logic [4:0] OFF_CMD    = 5'h00;
  localparam logic [4:0] OFF_MODE   = 5'h01;
  localparam logic [4:0] OFF_SA_LO  = 5'h02;
  localparam logic [4:0] OFF_SA_HI  = 5'h03;
  localparam logic [4:0] OFF_CNT_LO = 5'h04;
  localparam logic [4:0] OFF_CNT_HI = 5'h05;
  localparam logic [4:0] OFF_STAT   = 5'h07;
  localparam logic [4:0] OFF_DATA   = 5'h10;

  localparam logic [1:0] XFER_NONE = 2'b00;
  localparam logic [1:0] XFER_RD   = 2'b01;
  localparam logic [1:0] XFER_WR   = 2'b10;
  localparam logic [1:0] XFER_BAD  = 2'b11;

  localparam int CMD_ABORT_BIT = 5;
  localparam int STAT_RX_BIT   = 0;
  localparam int STAT_TX_BIT   = 1;
  localparam int STAT_DONE_BIT = 6;
  localparam logic [7:0] STAT_MASK = 8'h43;
endpackage

// File: rtl/rdma_addr_gen.sv
module rdma_addr_gen
  import rdma_pkg::*;
#(
  parameter int BUF_AW = 10
) (
  input  logic [REG_W-1:0]  addr_q,
  input  logic              ext_mode,
  input  logic              word_mode,
  input  logic [REG_W-1:0]  count_q,
  output logic [BUF_AW-1:0] eff_addr,
  output logic [REG_W-1:0]  addr_next,
  output logic [REG_W-1:0]  count_next
);
  localparam int WIN_AW = BUF_AW - 2;

  function automatic logic [BUF_AW-1:0] fold(input logic [BUF_AW-1:0] a, input logic ext);
    fold = ext ? a : {2'b01, a[WIN_AW-1:0]};
  endfunction

  logic [BUF_AW-1:0] step;
  logic [BUF_AW-1:0] bumped;
  logic [REG_W-1:0]  cstep;

  assign step     = word_mode ? BUF_AW'(2) : BUF_AW'(1);
  assign cstep    = word_mode ? REG_W'(2) : REG_W'(1);
  assign eff_addr = fold(addr_q[BUF_AW-1:0], ext_mode);
  assign bumped   = fold(eff_addr + step, ext_mode);

  generate
    if (BUF_AW < REG_W) begin : g_pad
      assign addr_next = {{(REG_W-BUF_AW){1'b0}}, bumped};
    end else begin : g_full
      assign addr_next = bumped;
    end
  endgenerate

  assign count_next = (count_q > cstep) ? (count_q - cstep) : '0;
endmodule

// File: rtl/rdma_sram.sv
module rdma_sram #(
  parameter int WORD_AW = 9
) (
  input  logic               clk,
  input  logic               rd_en,
  input  logic [WORD_AW-1:0] rd_idx,
  output logic [15:0]        rd_word,
  input  logic               wr_en,
  input  logic [WORD_AW-1:0] wr_idx,
  input  logic [1:0]         wr_be,
  input  logic [15:0]        wr_word
);
  localparam int DEPTH = 1 << WORD_AW;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) mem[wr_idx] <= wr_word[8*g +: 8];
      if (rd_en) q <= mem[rd_idx];
    end
    assign rd_word[8*g +: 8] = q;
  end
endmodule

// File: rtl/rdma_lane.sv
module rdma_lane (
  input  logic        word_mode,
  input  logic        odd,
  input  logic [15:0] mem_word,
  input  logic [15:0] host_wdata,
  output logic [15:0] rd_view,
  output logic [15:0] wr_word,
  output logic [1:0]  wr_be
);
  always_comb begin
    if (word_mode) begin
      rd_view = mem_word;
      wr_word = host_wdata;
      wr_be   = 2'b11;
    end else begin
      rd_view = {8'h00, odd ? mem_word[15:8] : mem_word[7:0]};
      wr_word = {host_wdata[7:0], host_wdata[7:0]};
      wr_be   = odd ? 2'b10 : 2'b01;
    end
  end
endmodule

// File: rtl/rdma_host_port.sv
module rdma_host_port
  import rdma_pkg::*;
#(
  parameter int BUF_AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_word,
  input  logic [4:0]  req_offset,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  output logic [15:0] rsp_data,
  input  logic        rx_done,
  input  logic        tx_done
);
  localparam int WORD_AW = BUF_AW - 1;

  rdma_state_t      state_q, state_d;
  logic [1:0]       page_q;
  logic             ext_q;
  logic [REG_W-1:0] addr_q, count_q;
  logic [7:0]       stat_q;
  logic             rsp_valid_q;
  logic [15:0]      rsp_data_q;

  logic [BUF_AW-1:0] eff_addr;
  logic [REG_W-1:0]  addr_next, count_next;
  logic [15:0]       mem_word, lane_rd, mem_wr_word;
  logic [1:0]        mem_be;

  logic acc, rd_acc, wr_acc, busy;
  logic is_cmd, cmd_abort, cmd_take, cmd_start;
  logic [1:0] cmd_field, field_view;
  logic cfg_wr, stat_wr, mode_wr;
  logic dp_rd, dp_wr, step_fire, done_evt;
  logic [7:0] stat_set, stat_clr;
  logic [15:0] rd_mux;

  assign busy      = (state_q != ST_IDLE);
  assign req_ready = (state_q != ST_FETCH);
  assign acc       = req_valid && req_ready;
  assign rd_acc    = acc && !req_write;
  assign wr_acc    = acc && req_write;

  assign is_cmd    = wr_acc && (req_offset == OFF_CMD);
  assign cmd_abort = req_wdata[CMD_ABORT_BIT];
  assign cmd_field = req_wdata[4:3];
  assign cmd_take  = is_cmd && (cmd_abort || (cmd_field != XFER_BAD));
  assign cmd_start = cmd_take && !cmd_abort && (cmd_field == XFER_RD || cmd_field == XFER_WR);

  assign cfg_wr  = wr_acc && (page_q == 2'd0) && !busy;
  assign stat_wr = wr_acc && (page_q == 2'd0) && (req_offset == OFF_STAT);
  assign mode_wr = wr_acc && (page_q == 2'd1) && (req_offset == OFF_MODE);

  assign dp_rd     = rd_acc && (req_offset == OFF_DATA) && (state_q == ST_RDY);
  assign dp_wr     = wr_acc && (req_offset == OFF_DATA) && (state_q == ST_WR);
  assign step_fire = dp_rd || dp_wr;

  rdma_addr_gen #(.BUF_AW(BUF_AW)) u_addr (
    .addr_q    (addr_q),
    .ext_mode  (ext_q),
    .word_mode (req_word),
    .count_q   (count_q),
    .eff_addr  (eff_addr),
    .addr_next (addr_next),
    .count_next(count_next)
  );

  rdma_lane u_lane (
    .word_mode (req_word),
    .odd       (eff_addr[0]),
    .mem_word  (mem_word),
    .host_wdata(req_wdata),
    .rd_view   (lane_rd),
    .wr_word   (mem_wr_word),
    .wr_be     (mem_be)
  );

  rdma_sram #(.WORD_AW(WORD_AW)) u_sram (
    .clk    (clk),
    .rd_en  (state_q == ST_FETCH),
    .rd_idx (eff_addr[BUF_AW-1:1]),
    .rd_word(mem_word),
    .wr_en  (dp_wr),
    .wr_idx (eff_addr[BUF_AW-1:1]),
    .wr_be  (mem_be),
    .wr_word(mem_wr_word)
  );

  assign done_evt = (cmd_start && (count_q == '0)) ||
                    (step_fire && (count_next == '0));

  always_comb begin
    stat_set = 8'h00;
    stat_set[STAT_RX_BIT]   = rx_done;
    stat_set[STAT_TX_BIT]   = tx_done;
    stat_set[STAT_DONE_BIT] = done_evt;
    stat_clr = stat_wr ? (req_wdata[7:0] & STAT_MASK) : 8'h00;
  end

  always_comb begin
    state_d = state_q;
    if (cmd_take) begin
      if (cmd_abort) state_d = ST_IDLE;
      else if (cmd_field == XFER_RD) state_d = (count_q == '0) ? ST_IDLE : ST_FETCH;
      else if (cmd_field == XFER_WR) state_d = (count_q == '0) ? ST_IDLE : ST_WR;
    end else if (step_fire) begin
      if (count_next == '0) state_d = ST_IDLE;
      else state_d = (state_q == ST_RDY) ? ST_FETCH : ST_WR;
    end else if (state_q == ST_FETCH) begin
      state_d = ST_RDY;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_FETCH, ST_RDY: field_view = XFER_RD;
      ST_WR:            field_view = XFER_WR;
      default:          field_view = XFER_NONE;
    endcase
  end

  always_comb begin
    rd_mux = 16'h0000;
    if (req_offset == OFF_CMD) begin
      rd_mux = {8'h00, page_q, 1'b0, field_view, 3'b000};
    end else if (req_offset == OFF_DATA) begin
      rd_mux = (state_q == ST_RDY) ? lane_rd : 16'h0000;
    end else if (page_q == 2'd1) begin
      if (req_offset == OFF_MODE) rd_mux = {15'h0000, ext_q};
    end else if (page_q == 2'd0) begin
      case (req_offset)
        OFF_SA_LO:  rd_mux = {8'h00, addr_q[7:0]};
        OFF_SA_HI:  rd_mux = {8'h00, addr_q[15:8]};
        OFF_CNT_LO: rd_mux = {8'h00, count_q[7:0]};
        OFF_CNT_HI: rd_mux = {8'h00, count_q[15:8]};
        OFF_STAT:   rd_mux = {8'h00, stat_q};
        default:    rd_mux = 16'h0000;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      page_q      <= 2'd0;
      ext_q       <= 1'b0;
      addr_q      <= '0;
      count_q     <= '0;
      stat_q      <= 8'h00;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= 16'h0000;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rd_acc;
      if (rd_acc) rsp_data_q <= rd_mux;
      stat_q <= ((stat_q & ~stat_clr) | stat_set) & STAT_MASK;
      if (cmd_take) page_q <= req_wdata[7:6];
      if (mode_wr) ext_q <= req_wdata[0];
      if (cfg_wr) begin
        case (req_offset)
          OFF_SA_LO:  addr_q[7:0]   <= req_wdata[7:0];
          OFF_SA_HI:  addr_q[15:8]  <= req_wdata[7:0];
          OFF_CNT_LO: count_q[7:0]  <= req_wdata[7:0];
          OFF_CNT_HI: count_q[15:8] <= req_wdata[7:0];
          default: ;
        endcase
      end
      if (step_fire) begin
        addr_q  <= addr_next;
        count_q <= count_next;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  assert_rsp_after_read_R14: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);
  assert_no_stray_rsp_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rsp_valid);
  assert_busy_has_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (count_q != '0));
  assert_byte_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !req_word) |=> (count_q == $past(count_q) - 16'd1));
  assert_abort_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && cmd_abort) |=> (state_q == ST_IDLE && $stable(count_q)));
  assert_bad_cmd_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && !cmd_abort && cmd_field == XFER_BAD) |=>
      (state_q == $past(state_q) && page_q == $past(page_q)));
  assert_compat_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !ext_q) |=> (addr_q[BUF_AW-1 -: 2] == 2'b01));
endmodule

// File: tb/rdma_host_port_tb.sv
module rdma_host_port_tb;
  localparam int AW = 6;
  localparam int NB = 1 << AW;
  localparam logic [4:0] O_CMD = 5'h00, O_MODE = 5'h01, O_SAL = 5'h02, O_SAH = 5'h03,
                         O_CL = 5'h04, O_CH = 5'h05, O_ST = 5'h07, O_DP = 5'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_word = 0, rx_done = 0, tx_done = 0;
  logic [4:0] req_offset = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_data;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;
  logic [7:0] bm [NB];

  always #4 clk = ~clk;

  rdma_host_port #(.BUF_AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_offset(req_offset),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rx_done(rx_done), .tx_done(tx_done));

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] off, logic [15:0] d, logic word = 0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_word = word; req_offset = off; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [4:0] off, logic word, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_word = word; req_offset = off;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (!rsp_valid) begin checks++; errors++; $display("FAIL R14 actual=0 expected=1 rsp_valid"); end
    d = rsp_data;
  endtask

  task automatic load(logic [15:0] a, logic [15:0] c);
    wr(O_SAL, {8'h0, a[7:0]}); wr(O_SAH, {8'h0, a[15:8]});
    wr(O_CL, {8'h0, c[7:0]});  wr(O_CH, {8'h0, c[15:8]});
  endtask

  task automatic set_mode(logic ext);
    wr(O_CMD, 16'h40); wr(O_MODE, {15'h0, ext}); wr(O_CMD, 16'h00);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    chk("R1 ready", {15'h0, req_ready}, 16'h1);
    chk("R1 rsp", {15'h0, rsp_valid}, 16'h0);
    rst_n = 1;
    rd(O_CMD, 0, d); chk("R1 cmd", d, 16'h0);
    rd(O_CL, 0, d);  chk("R1 count", d, 16'h0);
    rd(O_SAL, 0, d); chk("R1 addr", d, 16'h0);
    rd(O_ST, 0, d);  chk("R1 status", d, 16'h0);
    wr(O_CMD, 16'h40); rd(O_MODE, 0, d); chk("R1 mode", d, 16'h0); wr(O_CMD, 16'h00);

    // R4 R11: full byte write sweep in extension mode
    set_mode(1);
    load(16'h0000, 16'(NB));
    wr(O_CMD, 16'h10);
    rd(O_CMD, 0, d); chk("R4 field view", d, 16'h10);
    for (int i = 0; i < NB; i++) begin wr(O_DP, {8'h0, pat(i)}); bm[i] = pat(i); end
    rd(O_ST, 0, d);  chk("R7 done set", d, 16'h40);
    rd(O_CMD, 0, d); chk("R7 idle", d, 16'h0);
    rd(O_SAL, 0, d); chk("R11 wrap to 0", d, 16'h0);
    wr(O_ST, 16'h40); rd(O_ST, 0, d); chk("R13 clear done", d, 16'h0);

    // R3 R6: word read sweep
    load(16'h0000, 16'(NB));
    wr(O_CMD, 16'h08);
    chk("R3 ready low during fetch", {15'h0, req_ready}, 16'h0);
    for (int k = 0; k < NB/2; k++) begin
      rd(O_DP, 1, d); chk("R6 word lanes", d, {bm[2*k+1], bm[2*k]});
    end
    rd(O_ST, 0, d); chk("R7 done after words", d, 16'h40);
    wr(O_ST, 16'h40);

    // R5 R11: byte read wrapping from 5
    load(16'h0005, 16'(NB));
    wr(O_CMD, 16'h08);
    for (int i = 0; i < NB; i++) begin
      rd(O_DP, 0, d); chk("R5 byte read", d, {8'h0, bm[(5+i) % NB]});
    end
    rd(O_SAL, 0, d); chk("R11 address wrap", d, 16'h5);
    wr(O_ST, 16'h40);

    // R10: compatibility window
    set_mode(0);
    load(16'h0000, 16'd20);
    wr(O_CMD, 16'h08);
    for (int i = 0; i < 20; i++) begin
      rd(O_DP, 0, d); chk("R10 window read", d, {8'h0, bm[NB/4 + (i % (NB/4))]});
    end
    rd(O_SAL, 0, d); chk("R10 final address", d, 16'(NB/4 + 4));
    load(16'hAB03, 16'd2);
    wr(O_CMD, 16'h08);
    rd(O_DP, 0, d); chk("R10 fold high bits", d, {8'h0, bm[NB/4 + 3]});
    rd(O_DP, 0, d); chk("R10 fold next", d, {8'h0, bm[NB/4 + 4]});
    load(16'h001E, 16'd4);
    wr(O_CMD, 16'h10);
    wr(O_DP, 16'hBEEF, 1); bm[30] = 8'hEF; bm[31] = 8'hBE;
    wr(O_DP, 16'hCAFE, 1); bm[16] = 8'hFE; bm[17] = 8'hCA;
    rd(O_SAL, 0, d); chk("R10 word wrap address", d, 16'h12);
    set_mode(1);
    load(16'd30, 16'd2); wr(O_CMD, 16'h08);
    rd(O_DP, 1, d); chk("R10 word at window top", d, 16'hBEEF);
    load(16'd16, 16'd2); wr(O_CMD, 16'h08);
    rd(O_DP, 1, d); chk("R10 word wrapped to base", d, 16'hCAFE);
    wr(O_ST, 16'h40);

    // R6: odd count in word mode
    load(16'h0020, 16'd3); wr(O_CMD, 16'h08);
    rd(O_DP, 1, d); chk("R6 first word", d, {bm[33], bm[32]});
    rd(O_CL, 0, d); chk("R6 count minus two", d, 16'h1);
    rd(O_DP, 1, d); chk("R6 second word", d, {bm[35], bm[34]});
    rd(O_CL, 0, d); chk("R6 count saturates", d, 16'h0);
    rd(O_ST, 0, d); chk("R7 done odd count", d, 16'h40);
    wr(O_ST, 16'h40);

    // R8: abort mid transfer
    load(16'h0000, 16'd10); wr(O_CMD, 16'h08);
    for (int i = 0; i < 3; i++) begin rd(O_DP, 0, d); chk("R8 pre-abort read", d, {8'h0, bm[i]}); end
    wr(O_CMD, 16'h20);
    rd(O_CL, 0, d);  chk("R8 count kept", d, 16'd7);
    rd(O_SAL, 0, d); chk("R8 address kept", d, 16'd3);
    rd(O_ST, 0, d);  chk("R8 no done", d, 16'h0);
    rd(O_DP, 0, d);  chk("R8 idle data port", d, 16'h0);

    // R2: config writes ignored while busy
    load(16'h0000, 16'd2); wr(O_CMD, 16'h10);
    wr(O_CL, 16'h09);
    rd(O_CL, 0, d); chk("R2 count locked while busy", d, 16'h2);
    wr(O_CMD, 16'h20);

    // R9: illegal encoding
    load(16'h0012, 16'h1234);
    wr(O_CMD, 16'h18);
    rd(O_CMD, 0, d); chk("R9 stays idle", d, 16'h0);
    wr(O_CMD, 16'h58);
    rd(O_CL, 0, d);  chk("R9 page kept", d, 16'h34);
    rd(O_CH, 0, d);  chk("R2 count high", d, 16'h12);
    rd(O_DP, 0, d);  chk("R9 no transfer", d, 16'h0);

    // R12: page select
    wr(O_CMD, 16'h40);
    rd(O_CL, 0, d);   chk("R12 page1 hides count", d, 16'h0);
    rd(O_CMD, 0, d);  chk("R12 page readback", d, 16'h40);
    rd(O_MODE, 0, d); chk("R12 mode visible", d, 16'h1);
    wr(O_CL, 16'h55);
    wr(O_CMD, 16'h00);
    rd(O_CL, 0, d);   chk("R12 page1 write ignored", d, 16'h34);

    // R13: status write-one-to-clear
    @(negedge clk); rx_done = 1; tx_done = 1;
    @(negedge clk); rx_done = 0; tx_done = 0;
    rd(O_ST, 0, d); chk("R13 rx tx set", d, 16'h03);
    wr(O_ST, 16'h01); rd(O_ST, 0, d); chk("R13 clear bit0", d, 16'h02);
    wr(O_ST, 16'h00); rd(O_ST, 0, d); chk("R13 zero keeps", d, 16'h02);
    wr(O_ST, 16'h02); rd(O_ST, 0, d); chk("R13 clear bit1", d, 16'h00);

    // R7: zero count and writes after completion
    load(16'h0000, 16'h0000); wr(O_CMD, 16'h08);
    rd(O_ST, 0, d);  chk("R7 zero count done", d, 16'h40);
    rd(O_CMD, 0, d); chk("R7 zero count idle", d, 16'h0);
    wr(O_ST, 16'h40);
    load(16'h0008, 16'd1); wr(O_CMD, 16'h10);
    wr(O_DP, 16'h005A);
    wr(O_DP, 16'h0077);
    load(16'h0008, 16'd1); wr(O_CMD, 16'h08);
    rd(O_DP, 0, d); chk("R7 late write ignored", d, 16'h5A);

    finish_run();
  end
endmodule